// File: doc/BRIEF.md
# Integrate-and-Dump CIC Decimator

This block lowers the sample rate of a signed data stream by a fixed integer ratio using a cascaded integrator-comb structure with one stage pair removed. A stage-N CIC decimator behaves like N length-R moving sums convolved together and then sampled every R inputs. Here the innermost integrator and its matching comb are merged into a single accumulator. That accumulator adds up exactly R consecutive high-rate values, hands the total to the low-rate section, and starts the next total from zero. As a result, the design needs ORDER-1 high-rate integrators, one integrate-and-dump stage and ORDER-1 low-rate combs.

High-rate samples arrive with a valid strobe. Cycles without the strobe are ignored. Once in every RATIO accepted samples, the block produces one decimated sample with a single-cycle output-valid pulse. All arithmetic is two's complement and wraps at the internal width, which is the input width plus ORDER times the ceiling of log2(RATIO). Because of this width, the wrapped result equals the exact filter output.

Top module: `cic_decim_dump`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `out_data` is 0. After reset the filter behaves as if every earlier input were zero.
- R2: `out_valid` is high for exactly one cycle for each group of RATIO accepted samples. The first group is the first RATIO samples accepted after reset. No pulse appears while a group is still incomplete, however many idle cycles pass.
- R3: A cycle with `in_valid` = 0 is ignored. The value on `in_data` in that cycle changes neither any later output nor the time at which it appears.
- R4: An input of 1 as the first sample after reset, followed by zeros, gives decimated outputs h[mR+R-1] for m = 0, 1, 2, ... Here h is the ORDER-fold convolution of a length-RATIO all-ones sequence.
- R5: For any input sequence, output m equals output m of a full ORDER-stage CIC decimator. That reference has ORDER input-rate integrators, keeps every RATIO-th value (the RATIO-th, 2·RATIO-th, ... accepted sample), and applies ORDER combs with a differential delay of one. All values are taken modulo 2^W and read as signed W-bit numbers.
- R6: A constant input x, once ORDER groups have passed, gives outputs equal to x·RATIO^ORDER.
- R7: Suppose the sample that completes a group is accepted at clock edge k. Then `out_valid` is 0 after edges k to k+ORDER-2 and is 1 after edge k+ORDER-1.
- R8: Full-scale inputs (the most positive and the most negative IN_W-bit values) held constant produce exactly x·RATIO^ORDER at the W-bit output, with no wrap. W = IN_W + ORDER·ceil(log2 RATIO).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High-rate sample strobe |
| in_data | input | IN_W | Signed high-rate sample |
| out_valid | output | 1 | One-cycle pulse per decimated sample |
| out_data | output | W | Signed decimated sample, W = IN_W + ORDER·ceil(log2 RATIO) |

## Verification
The bench builds the block with IN_W = 8, ORDER = 3 and RATIO = 5. A ratio that is not a power of two makes the group counter wrap away from a binary boundary. It also leaves the internal width (17 bits) above the true gain of 125, so the full-scale tests check exact results rather than wrapped ones. Three stages mean two high-rate integrators feed the dump stage and two combs follow it. This exposes ordering and latency mistakes in both chains and gives a two-cycle gap to check after the dump. The impulse test compares against a convolution the bench computes separately. Stimulus with gaps in the strobe, carrying garbage data on the idle cycles, is compared against a full-order reference model.

// File: rtl/cic_dec_pkg.sv
package cic_dec_pkg;
  // Internal word width that holds the full filter gain RATIO^ORDER.
  function automatic int acc_width(input int in_w, input int order, input int ratio);
    return in_w + order * $clog2(ratio);
  endfunction
endpackage

// File: rtl/cic_hr_integ.sv
// Input-rate integrator. Exposes its next value combinationally so the
// following stage sees the same sample index (no per-stage sample delay).
module cic_hr_integ #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] sum_next
);
  logic signed [W-1:0] acc;

  assign sum_next = acc + din;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      acc <= sum_next;
    end
  end

  // R3: idle cycles leave the running sum untouched
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));
endmodule

// File: rtl/cic_dump_integ.sv
// Integrate-and-dump stage: sums RATIO accepted values, emits the total on
// the RATIO-th one and restarts from zero with the next value.
module cic_dump_integ #(
  parameter int W     = 24,
  parameter int RATIO = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic                dump_valid,
  output logic signed [W-1:0] dump_data
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0]       cnt;
  logic signed [W-1:0] part;
  logic signed [W-1:0] total;
  logic                at_last;

  assign at_last = (cnt == LAST);
  assign total   = part + din;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      part       <= '0;
      dump_valid <= 1'b0;
      dump_data  <= '0;
    end else begin
      dump_valid <= 1'b0;
      if (en) begin
        if (at_last) begin
          dump_data  <= total;
          dump_valid <= 1'b1;
          part       <= '0;
          cnt        <= '0;
        end else begin
          part <= total;
          cnt  <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: counter stays within one group
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R2: the RATIO-th accepted value triggers a dump
  p_dump_on_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (en && at_last) |=> dump_valid);
  // R2: no dump without a completed group
  p_no_early_dump_r2: assert property (@(posedge clk) disable iff (rst)
    !(en && at_last) |=> !dump_valid);
  // R5: next group starts from zero, not from the old total
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (en && at_last) |=> (part == '0) && (cnt == '0));
endmodule

// File: rtl/cic_lr_comb.sv
// Low-rate comb with differential delay one, registered output.
module cic_lr_comb #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_in,
  input  logic signed [W-1:0] din,
  output logic                v_out,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      dout  <= '0;
      v_out <= 1'b0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        dout <= din - prev;
        prev <= din;
      end
    end
  end

  // R7: each comb adds exactly one cycle to the valid path
  p_comb_lat_r7: assert property (@(posedge clk) disable iff (rst)
    v_in |=> v_out);
  p_comb_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> !v_out);
  // R3: output holds between low-rate samples
  p_comb_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(dout));
endmodule

// File: rtl/cic_decim_dump.sv
module cic_decim_dump
  import cic_dec_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int ORDER = 4,
  parameter int RATIO = 8,
  localparam int W    = acc_width(IN_W, ORDER, RATIO)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      in_data,
  output logic                 out_valid,
  output logic [W-1:0]         out_data
);
  logic signed [W-1:0] ichain [0:ORDER-1];
  logic signed [W-1:0] cdata  [0:ORDER-1];
  logic                cvalid [0:ORDER-1];

  // Sign-extend the input to the internal width
  assign ichain[0] = W'($signed(in_data));

  genvar k;
  generate
    for (k = 0; k < ORDER - 1; k++) begin : g_integ
      cic_hr_integ #(.W(W)) u_integ (
        .clk      (clk),
        .rst      (rst),
        .en       (in_valid),
        .din      (ichain[k]),
        .sum_next (ichain[k+1])
      );
    end
  endgenerate

  cic_dump_integ #(.W(W), .RATIO(RATIO)) u_dump (
    .clk        (clk),
    .rst        (rst),
    .en         (in_valid),
    .din        (ichain[ORDER-1]),
    .dump_valid (cvalid[0]),
    .dump_data  (cdata[0])
  );

  generate
    for (k = 1; k < ORDER; k++) begin : g_comb
      cic_lr_comb #(.W(W)) u_comb (
        .clk   (clk),
        .rst   (rst),
        .v_in  (cvalid[k-1]),
        .din   (cdata[k-1]),
        .v_out (cvalid[k]),
        .dout  (cdata[k])
      );
    end
  endgenerate

  assign out_valid = cvalid[ORDER-1];
  assign out_data  = cdata[ORDER-1];

  // R2: the output strobe is a single-cycle pulse
  p_out_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: tb/tb_cic_decim_dump.sv
module tb_cic_decim_dump;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 8;
  localparam int ORDER = 3;
  localparam int RATIO = 5;
  localparam int W     = IN_W + ORDER * $clog2(RATIO);
  localparam int NV    = 40;

  // {valid, data}
  localparam logic [8:0] STIM [NV] = '{
    9'h105, 9'h1F0, 9'h07F, 9'h180, 9'h17F, 9'h133, 9'h0AA, 9'h1C8,
    9'h101, 9'h100, 9'h1FF, 9'h155, 9'h022, 9'h1E0, 9'h110, 9'h17F,
    9'h17F, 9'h180, 9'h180, 9'h0FF, 9'h13C, 9'h1D4, 9'h109, 9'h1F7,
    9'h177, 9'h055, 9'h1A0, 9'h160, 9'h102, 9'h1FE, 9'h1ED, 9'h013,
    9'h143, 9'h1BD, 9'h1AB, 9'h155, 9'h0C3, 9'h111, 9'h1EE, 9'h1DD
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic            out_valid;
  logic [W-1:0]    out_data;

  cic_decim_dump #(.IN_W(IN_W), .ORDER(ORDER), .RATIO(RATIO)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input string req, input longint got, input longint exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Captured outputs
  longint got_v [0:63];
  int     got_n = 0;
  always @(negedge clk) begin
    if (!rst && out_valid && got_n < 64) begin
      got_v[got_n] = longint'($signed(out_data));
      got_n = got_n + 1;
    end
  end

  // Full-order reference model
  longint intg [0:ORDER-1];
  longint combp [0:ORDER-1];
  int     mcnt;
  longint exp_v [0:63];
  int     exp_n;

  function automatic longint wrapw(input longint v);
    logic signed [W-1:0] t;
    t = v[W-1:0];
    return longint'(t);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < ORDER; k++) begin intg[k] = 0; combp[k] = 0; end
    mcnt = 0; exp_n = 0;
  endtask

  task automatic model_push(input longint x);
    longint v, d;
    v = x;
    for (int k = 0; k < ORDER; k++) begin
      intg[k] = wrapw(intg[k] + v);
      v = intg[k];
    end
    mcnt++;
    if (mcnt == RATIO) begin
      mcnt = 0;
      for (int k = 0; k < ORDER; k++) begin
        d = wrapw(v - combp[k]);
        combp[k] = v;
        v = d;
      end
      if (exp_n < 64) begin exp_v[exp_n] = v; exp_n++; end
    end
  endtask

  task automatic send(input logic v, input logic [IN_W-1:0] d);
    in_valid = v;
    in_data  = d;
    if (v) model_push(longint'($signed(d)));
    @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    got_n = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 8'hA5);
  endtask

  task automatic compare_all(input string req);
    chk({req, " output count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) chk(req, got_v[i], exp_v[i]);
  endtask

  function automatic longint ratio_pow();
    longint p = 1;
    for (int k = 0; k < ORDER; k++) p = p * RATIO;
    return p;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  longint h [0:31];
  int     hlen;

  initial begin
    @(negedge clk);
    // R1: reset state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 out_data in reset", longint'(out_data), 0);
    rst = 1'b0;
    model_reset();
    got_n = 0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_data after reset", longint'(out_data), 0);

    // R5/R3: table walk with gaps carrying garbage data
    for (int i = 0; i < NV; i++) send(STIM[i][8], STIM[i][7:0]);
    idle(ORDER + 2);
    compare_all("R5 table");

    // R2: incomplete group never dumps, however long the idle
    do_reset();
    for (int i = 0; i < RATIO - 1; i++) send(1'b1, 8'(i + 3));
    idle(30);
    chk("R2 no output on partial group", got_n, 0);
    send(1'b1, 8'h02);
    idle(ORDER + 2);
    chk("R2 one output after group completes", got_n, 1);
    compare_all("R3 idle data ignored");

    // R7: latency and single pulse
    do_reset();
    for (int i = 0; i < RATIO; i++) send(1'b1, 8'h01);
    in_valid = 1'b0;
    for (int i = 0; i < ORDER - 1; i++) begin
      chk("R7 out_valid low before latency", out_valid, 0);
      @(negedge clk);
    end
    chk("R7 out_valid high at latency", out_valid, 1);
    @(negedge clk);
    chk("R2 pulse lasts one cycle", out_valid, 0);

    // R4: impulse against an independent convolution
    do_reset();
    hlen = 1; h[0] = 1;
    for (int k = 0; k < ORDER; k++) begin
      longint t [0:31];
      for (int i = 0; i < 32; i++) t[i] = 0;
      for (int i = 0; i < hlen; i++)
        for (int j = 0; j < RATIO; j++) t[i+j] += h[i];
      hlen = hlen + RATIO - 1;
      for (int i = 0; i < 32; i++) h[i] = t[i];
    end
    send(1'b1, 8'h01);
    for (int i = 1; i < (ORDER + 1) * RATIO; i++) send(1'b1, 8'h00);
    idle(ORDER + 2);
    chk("R4 impulse output count", got_n, ORDER + 1);
    for (int m = 0; m <= ORDER && m < got_n; m++)
      chk("R4 impulse tap", got_v[m], (m*RATIO + RATIO - 1 < hlen) ? h[m*RATIO + RATIO - 1] : 0);

    // R6: DC gain with a mid value
    do_reset();
    for (int i = 0; i < (ORDER + 2) * RATIO; i++) send(1'b1, 8'd37);
    idle(ORDER + 2);
    chk("R6 DC gain", got_v[got_n-1], 37 * ratio_pow());
    compare_all("R6 DC vs model");

    // R8: full-scale positive and negative
    do_reset();
    for (int i = 0; i < (ORDER + 1) * RATIO; i++) send(1'b1, 8'h7F);
    idle(ORDER + 2);
    chk("R8 full-scale positive", got_v[got_n-1], 127 * ratio_pow());
    do_reset();
    for (int i = 0; i < (ORDER + 1) * RATIO; i++) send(1'b1, 8'h80);
    idle(ORDER + 2);
    chk("R8 full-scale negative", got_v[got_n-1], -128 * ratio_pow());

    // R5: alternating extremes with periodic gaps
    do_reset();
    for (int i = 0; i < 8 * RATIO; i++) begin
      send(1'b1, (i % 3 == 0) ? 8'h80 : 8'h7F);
      if (i % 4 == 1) send(1'b0, 8'h5A);
    end
    idle(ORDER + 2);
    compare_all("R5 alternating");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule